// File: doc/BRIEF.md
# SHA-256 Compression Engine with Resumable Chaining State

This block computes the SHA-256 compression function on one 512-bit message block at a time, behind a 32-bit register bus with a select, a write enable, an 8-bit word address, write data, read data and an error flag. Software writes the block as sixteen 32-bit words and then writes a command. The command either starts a new hash from the standard initial value or continues a chained hash from the current chaining value. Software then polls the status word until it is non-zero and reads the 256-bit result as eight words. Message padding and the length field are prepared by software.

The eight chaining words can also be written over the bus. Software can save the intermediate digest of a long message and later load it back, then continue with the remaining blocks. The result is identical to processing all blocks in one run.

Inside, one round is computed per clock. A control state machine has three states. IDLE waits for a command. ROUND runs the 64 rounds. FOLD adds the working variables into the chaining words. The transitions are: IDLE to ROUND when a command is accepted, ROUND to ROUND while rounds remain, ROUND to FOLD on round 63, and FOLD to IDLE unconditionally. The message schedule uses a 16-word sliding window.

Top module: `sha256_mm_engine`

## Requirements
- R1: After reset, status (address 0x09) reads 0x1: bit 0 is ready = 1 and bit 1 is digest-valid = 0. The digest words read the standard initial value, with 0x20 = 0x6a09e667 and 0x27 = 0x5be0cd19.
- R2: Writing bit 0 (init) of the command word at 0x08 while ready compresses the block held at 0x10..0x1F onto the standard initial value. Address 0x10 is bits 511:480 of the block. The 256-bit result is read at 0x20..0x27, with 0x20 the most significant word.
- R3: Writing bit 1 (next) of 0x08 while ready compresses the block onto the current chaining value. For the standard two-block test message the result is 248d6a61...19db06c1.
- R4: Writing 0x30..0x37 while ready loads the chaining words, with 0x30 = bits 255:224 and 0x37 = bits 31:0. Loading a first block's intermediate digest and then issuing next on the second block gives the same result as running both blocks back to back.
- R5: When a command is accepted, status reads 0 (both bits clear) from the next cycle on. Ready and digest-valid return to 1 together, 65 clock edges after the accepting edge.
- R6: While a compression is in progress, writes to 0x30..0x37 and further commands are ignored. This includes the final fold cycle.
- R7: err is high in the cycle of an access with sel = 1 to an unmapped address, or of a write to 0x09 or 0x20..0x27. Such writes change nothing. The mapped addresses are 0x08 (command, reads 0), 0x09, 0x10..0x1F (read/write), 0x20..0x27 (read-only) and 0x30..0x37 (read/write, reads return the chaining words).
- R8: A command word with both bits set acts as init.
- R9: The command bits are single-cycle pulses. Address 0x08 reads 0, and a finished engine stays idle, with its digest unchanged, until a new command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Bus access in this cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word (combinational) |
| err | output | 1 | Access error in this cycle |

## Verification
A chaining-state write and the end of a compression can fall in the same cycle. The bench provokes this by counting clock edges after a next command and placing a write to 0x30 exactly in the FOLD cycle, one edge before ready returns. The write is judged ignored when the digest read afterwards equals a bench model of the compression over the old chaining value, and when status reads 0 just before that cycle and 0x3 just after it. A second command issued one cycle after the first is judged the same way, against the result of the first command alone.

// File: rtl/sha256_mm_pkg.sv
package sha256_mm_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 16;
    localparam int DIG_WORDS = 8;
    localparam int ROUNDS    = 64;
    localparam int ADDR_W    = 8;
    localparam int BLK_AW    = $clog2(BLK_WORDS);
    localparam int DIG_AW    = $clog2(DIG_WORDS);
    localparam int RND_W     = $clog2(ROUNDS);

    localparam logic [ADDR_W-1:0] ADR_CMD  = 8'h08;
    localparam logic [ADDR_W-1:0] ADR_STAT = 8'h09;
    localparam logic [ADDR_W-1:0] ADR_BLK  = 8'h10;
    localparam logic [ADDR_W-1:0] ADR_DIG  = 8'h20;
    localparam logic [ADDR_W-1:0] ADR_CHN  = 8'h30;
    localparam int CMD_INIT_BIT = 0;
    localparam int CMD_NEXT_BIT = 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef enum logic [1:0] {ST_IDLE, ST_ROUND, ST_FOLD} eng_state_t;

    function automatic word_t rotr(word_t x, int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_s0(word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_s1(word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t sml_s0(word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sml_s1(word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t iv_word(int i);
        case (i)
            0: return 32'h6a09e667;  1: return 32'hbb67ae85;
            2: return 32'h3c6ef372;  3: return 32'ha54ff53a;
            4: return 32'h510e527f;  5: return 32'h9b05688c;
            6: return 32'h1f83d9ab;  default: return 32'h5be0cd19;
        endcase
    endfunction

    function automatic word_t k_word(logic [RND_W-1:0] i);
        case (i)
            6'd0:  return 32'h428a2f98; 6'd1:  return 32'h71374491; 6'd2:  return 32'hb5c0fbcf; 6'd3:  return 32'he9b5dba5;
            6'd4:  return 32'h3956c25b; 6'd5:  return 32'h59f111f1; 6'd6:  return 32'h923f82a4; 6'd7:  return 32'hab1c5ed5;
            6'd8:  return 32'hd807aa98; 6'd9:  return 32'h12835b01; 6'd10: return 32'h243185be; 6'd11: return 32'h550c7dc3;
            6'd12: return 32'h72be5d74; 6'd13: return 32'h80deb1fe; 6'd14: return 32'h9bdc06a7; 6'd15: return 32'hc19bf174;
            6'd16: return 32'he49b69c1; 6'd17: return 32'hefbe4786; 6'd18: return 32'h0fc19dc6; 6'd19: return 32'h240ca1cc;
            6'd20: return 32'h2de92c6f; 6'd21: return 32'h4a7484aa; 6'd22: return 32'h5cb0a9dc; 6'd23: return 32'h76f988da;
            6'd24: return 32'h983e5152; 6'd25: return 32'ha831c66d; 6'd26: return 32'hb00327c8; 6'd27: return 32'hbf597fc7;
            6'd28: return 32'hc6e00bf3; 6'd29: return 32'hd5a79147; 6'd30: return 32'h06ca6351; 6'd31: return 32'h14292967;
            6'd32: return 32'h27b70a85; 6'd33: return 32'h2e1b2138; 6'd34: return 32'h4d2c6dfc; 6'd35: return 32'h53380d13;
            6'd36: return 32'h650a7354; 6'd37: return 32'h766a0abb; 6'd38: return 32'h81c2c92e; 6'd39: return 32'h92722c85;
            6'd40: return 32'ha2bfe8a1; 6'd41: return 32'ha81a664b; 6'd42: return 32'hc24b8b70; 6'd43: return 32'hc76c51a3;
            6'd44: return 32'hd192e819; 6'd45: return 32'hd6990624; 6'd46: return 32'hf40e3585; 6'd47: return 32'h106aa070;
            6'd48: return 32'h19a4c116; 6'd49: return 32'h1e376c08; 6'd50: return 32'h2748774c; 6'd51: return 32'h34b0bcb5;
            6'd52: return 32'h391c0cb3; 6'd53: return 32'h4ed8aa4a; 6'd54: return 32'h5b9cca4f; 6'd55: return 32'h682e6ff3;
            6'd56: return 32'h748f82ee; 6'd57: return 32'h78a5636f; 6'd58: return 32'h84c87814; 6'd59: return 32'h8cc70208;
            6'd60: return 32'h90befffa; 6'd61: return 32'ha4506ceb; 6'd62: return 32'hbef9a3f7; default: return 32'hc67178f2;
        endcase
    endfunction
endpackage

// File: rtl/sha256_msg_window.sv
module sha256_msg_window
    import sha256_mm_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic                        shift,
    input  logic [BLK_WORDS*WORD_W-1:0] block,
    output word_t                       w_now
);
    word_t win_q [BLK_WORDS];
    word_t w_new;

    // Next schedule word from the window: taps at t-2, t-7, t-15, t-16.
    assign w_new = sml_s1(win_q[BLK_WORDS-2]) + win_q[BLK_WORDS-7]
                 + sml_s0(win_q[1]) + win_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BLK_WORDS; i++) win_q[i] <= '0;
        end else if (load) begin
            for (int i = 0; i < BLK_WORDS; i++)
                win_q[i] <= block[(BLK_WORDS-1-i)*WORD_W +: WORD_W];
        end else if (shift) begin
            for (int i = 0; i < BLK_WORDS-1; i++) win_q[i] <= win_q[i+1];
            win_q[BLK_WORDS-1] <= w_new;
        end
    end

    assign w_now = win_q[0];
endmodule

// File: rtl/sha256_round_fsm.sv
module sha256_round_fsm
    import sha256_mm_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_init,
    input  logic                        cmd_next,
    input  logic [BLK_WORDS*WORD_W-1:0] block,
    input  logic                        chn_we,
    input  logic [DIG_AW-1:0]           chn_idx,
    input  word_t                       chn_data,
    output logic                        ready,
    output logic                        dvalid,
    output logic [DIG_WORDS*WORD_W-1:0] chain
);
    eng_state_t        st_q, st_d;
    logic [RND_W-1:0]  rnd_q;
    word_t             hv_q [DIG_WORDS];
    word_t             wv_q [DIG_WORDS];
    word_t             w_now, t1, t2;
    logic              go, go_init, last_rnd, idle;

    assign idle     = (st_q == ST_IDLE);
    assign go       = (cmd_init | cmd_next) & idle;
    assign go_init  = go & cmd_init;          // init wins over next
    assign last_rnd = (rnd_q == RND_W'(ROUNDS-1));

    sha256_msg_window u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go),
        .shift (st_q == ST_ROUND),
        .block (block),
        .w_now (w_now)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (go) st_d = ST_ROUND;
            ST_ROUND: if (last_rnd) st_d = ST_FOLD;
            ST_FOLD:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // One compression round.
    always_comb begin
        t1 = wv_q[7] + big_s1(wv_q[4]) + ((wv_q[4] & wv_q[5]) ^ (~wv_q[4] & wv_q[6]))
           + k_word(rnd_q) + w_now;
        t2 = big_s0(wv_q[0]) + ((wv_q[0] & wv_q[1]) ^ (wv_q[0] & wv_q[2]) ^ (wv_q[1] & wv_q[2]));
    end

    // Working variables, round counter and chaining words.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd_q <= '0;
            for (int i = 0; i < DIG_WORDS; i++) begin
                hv_q[i] <= iv_word(i);
                wv_q[i] <= '0;
            end
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    rnd_q <= '0;
                    if (go) begin
                        for (int i = 0; i < DIG_WORDS; i++) begin
                            wv_q[i] <= go_init ? iv_word(i) : hv_q[i];
                            if (go_init) hv_q[i] <= iv_word(i);
                        end
                    end else if (chn_we) begin
                        hv_q[chn_idx] <= chn_data;
                    end
                end
                ST_ROUND: begin
                    rnd_q   <= rnd_q + 1'b1;
                    wv_q[0] <= t1 + t2;
                    wv_q[1] <= wv_q[0];
                    wv_q[2] <= wv_q[1];
                    wv_q[3] <= wv_q[2];
                    wv_q[4] <= wv_q[3] + t1;
                    wv_q[5] <= wv_q[4];
                    wv_q[6] <= wv_q[5];
                    wv_q[7] <= wv_q[6];
                end
                ST_FOLD: begin
                    for (int i = 0; i < DIG_WORDS; i++) hv_q[i] <= hv_q[i] + wv_q[i];
                end
                default: rnd_q <= '0;
            endcase
        end
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready  <= 1'b1;
            dvalid <= 1'b0;
        end else if (go) begin
            ready  <= 1'b0;
            dvalid <= 1'b0;
        end else if (st_q == ST_FOLD) begin
            ready  <= 1'b1;
            dvalid <= 1'b1;
        end
    end

    for (genvar g = 0; g < DIG_WORDS; g++) begin : g_chain
        assign chain[(DIG_WORDS-1-g)*WORD_W +: WORD_W] = hv_q[g];
    end
endmodule

// File: rtl/sha256_mm_engine.sv
module sha256_mm_engine
    import sha256_mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              err
);
    logic                        wr_cyc, hit_cmd, hit_stat, hit_blk, hit_dig, hit_chn;
    logic                        core_ready, core_valid;
    logic [DIG_WORDS*WORD_W-1:0] chain_q;
    logic [BLK_WORDS*WORD_W-1:0] blk_flat;
    word_t                       blk_q [BLK_WORDS];
    word_t                       dig_w [DIG_WORDS];

    assign wr_cyc   = sel & wr_en;
    assign hit_cmd  = (addr == ADR_CMD);
    assign hit_stat = (addr == ADR_STAT);
    assign hit_blk  = (addr[ADDR_W-1:BLK_AW] == ADR_BLK[ADDR_W-1:BLK_AW]);
    assign hit_dig  = (addr[ADDR_W-1:DIG_AW] == ADR_DIG[ADDR_W-1:DIG_AW]);
    assign hit_chn  = (addr[ADDR_W-1:DIG_AW] == ADR_CHN[ADDR_W-1:DIG_AW]);

    assign err = sel & (~(hit_cmd | hit_stat | hit_blk | hit_dig | hit_chn)
                        | (wr_en & (hit_stat | hit_dig)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BLK_WORDS; i++) blk_q[i] <= '0;
        end else if (wr_cyc && hit_blk) begin
            blk_q[addr[BLK_AW-1:0]] <= wdata;
        end
    end

    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_blk
        assign blk_flat[(BLK_WORDS-1-g)*WORD_W +: WORD_W] = blk_q[g];
    end

    for (genvar g = 0; g < DIG_WORDS; g++) begin : g_dig
        assign dig_w[g] = chain_q[(DIG_WORDS-1-g)*WORD_W +: WORD_W];
    end

    always_comb begin
        rdata = '0;
        if (hit_stat)                rdata = {{(WORD_W-2){1'b0}}, core_valid, core_ready};
        else if (hit_blk)            rdata = blk_q[addr[BLK_AW-1:0]];
        else if (hit_dig || hit_chn) rdata = dig_w[addr[DIG_AW-1:0]];
    end

    sha256_round_fsm u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_init (wr_cyc & hit_cmd & wdata[CMD_INIT_BIT]),
        .cmd_next (wr_cyc & hit_cmd & wdata[CMD_NEXT_BIT]),
        .block    (blk_flat),
        .chn_we   (wr_cyc & hit_chn),
        .chn_idx  (addr[DIG_AW-1:0]),
        .chn_data (wdata),
        .ready    (core_ready),
        .dvalid   (core_valid),
        .chain    (chain_q)
    );
endmodule

// File: rtl/sha256_mm_engine_chk.sv
module sha256_mm_engine_chk
    import sha256_mm_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        sel,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           addr,
    input logic [1:0]                  cmd_bits,
    input logic                        err,
    input logic                        core_ready,
    input logic                        core_valid,
    input logic [DIG_WORDS*WORD_W-1:0] chain
);
    logic [6:0] busy_cnt;
    logic       accept;

    assign accept = sel && wr_en && (addr == ADR_CMD) && (cmd_bits != 2'b00) && core_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           busy_cnt <= '0;
        else if (accept)      busy_cnt <= 7'd1;
        else if (!core_ready) busy_cnt <= busy_cnt + 7'd1;
    end

    // R7: no error without an access
    assert_err_needs_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !err);

    // R5: accepted command clears both status bits
    assert_accept_drops_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!core_ready && !core_valid));

    // R5: ready returns with digest-valid after the fixed latency
    assert_ready_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_ready) |-> (busy_cnt == 7'd66 && core_valid));

    // R7: write to the read-only digest window leaves the chain untouched
    assert_ro_write_keeps_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && addr[ADDR_W-1:DIG_AW] == ADR_DIG[ADDR_W-1:DIG_AW] && core_ready)
        |=> $stable(chain));

    // R6: chaining write during rounds is ignored
    assert_busy_chain_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en && addr[ADDR_W-1:DIG_AW] == ADR_CHN[ADDR_W-1:DIG_AW]
         && !core_ready && busy_cnt < 7'd65) |=> $stable(chain));
endmodule

bind sha256_mm_engine sha256_mm_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .wr_en      (wr_en),
    .addr       (addr),
    .cmd_bits   (wdata[1:0]),
    .err        (err),
    .core_ready (core_ready),
    .core_valid (core_valid),
    .chain      (chain_q)
);

// File: tb/sha256_mm_engine_tb.sv
module sha256_mm_engine_tb;
    logic        clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;

    always #10 clk = ~clk;   // 50 MHz

    sha256_mm_engine u_dut (.clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
                            .addr(addr), .wdata(wdata), .rdata(rdata), .err(err));

    int          n_chk = 0, n_fail = 0;
    bit          finished = 0;
    logic [31:0] rd;
    logic        er;

    localparam logic [255:0] IV = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
    localparam logic [31:0] KT [64] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

    function automatic logic [31:0] rr(logic [31:0] x, int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    // Bench reference model of one compression.
    function automatic logic [255:0] model(logic [255:0] h, logic [511:0] b);
        logic [31:0] w [64];
        logic [31:0] a, bb, c, d, e, f, g, hh, t1, t2;
        for (int t = 0; t < 16; t++) w[t] = b[511-32*t -: 32];
        for (int t = 16; t < 64; t++)
            w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
                 + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
        {a, bb, c, d, e, f, g, hh} = h;
        for (int t = 0; t < 64; t++) begin
            t1 = hh + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + KT[t] + w[t];
            t2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & bb) ^ (a & c) ^ (bb & c));
            hh = g; g = f; f = e; e = d + t1; d = c; c = bb; bb = a; a = t1 + t2;
        end
        return {h[255:224] + a, h[223:192] + bb, h[191:160] + c, h[159:128] + d,
                h[127:96] + e, h[95:64] + f, h[63:32] + g, h[31:0] + hh};
    endfunction

    task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr_en = w; addr = a; wdata = d;
        #5;
        rd = rdata; er = err;
        @(posedge clk);
        #1;
        sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put_block(input logic [511:0] b);
        for (int i = 0; i < 16; i++) bus(1'b1, 8'(8'h10 + i), b[511-32*i -: 32]);
    endtask

    task automatic put_state(input logic [255:0] s);
        for (int i = 0; i < 8; i++) bus(1'b1, 8'(8'h30 + i), s[255-32*i -: 32]);
    endtask

    task automatic get_digest(output logic [255:0] dg);
        for (int i = 0; i < 8; i++) begin
            bus(1'b0, 8'(8'h20 + i), 32'h0);
            dg[255-32*i -: 32] = rd;
        end
    endtask

    task automatic wait_done();
        int k = 0;
        do begin
            bus(1'b0, 8'h09, 32'h0);
            k++;
        end while (rd[0] == 1'b0 && k < 500);
    endtask

    task automatic hash(input logic [1:0] cmd, input logic [511:0] b, output logic [255:0] dg);
        put_block(b);
        bus(1'b1, 8'h08, {30'b0, cmd});
        wait_done();
        get_digest(dg);
    endtask

    function automatic logic [511:0] rnd_block();
        logic [511:0] b;
        for (int i = 0; i < 16; i++) b[511-32*i -: 32] = $urandom();
        return b;
    endfunction

    function automatic logic [255:0] rnd_state();
        logic [255:0] s;
        for (int i = 0; i < 8; i++) s[255-32*i -: 32] = $urandom();
        return s;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [511:0] blk, m0, m1, abc;
        logic [255:0] dg, exp_h, s, mid;
        logic         e_save;
        void'($urandom(32'd20150717));
        m0  = 512'h6162636462636465636465666465666765666768666768696768696a68696a6b696a6b6c6a6b6c6d6b6c6d6e6c6d6e6f6d6e6f706e6f70718000000000000000;
        m1  = 512'h1c0;
        abc = {32'h61626380, 448'h0, 32'h18};
        mid = 256'h85e655d6417a17953363376a624cde5c76e09589cac5f811cc4b32c1f20e533a;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        bus(1'b0, 8'h09, 0); chk("R1 status", rd, 32'h1);
        bus(1'b0, 8'h20, 0); chk("R1 digest0", rd, 32'h6a09e667);
        bus(1'b0, 8'h27, 0); chk("R1 digest7", rd, 32'h5be0cd19);

        // R2 init on a single-block message
        hash(2'b01, abc, dg);
        chk("R2 abc", dg, 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);
        chk("R2 model", dg, model(IV, abc));

        // R3 two-block chain
        hash(2'b01, m0, dg); chk("R3 first block", dg, mid);
        hash(2'b10, m1, dg);
        chk("R3 final", dg, 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1);

        // R4 restore and resume
        put_state(rnd_state());
        put_state(mid);
        hash(2'b10, m1, dg);
        chk("R4 restored final", dg, 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1);
        exp_h = dg;

        // R5/R6 state write falling in the fold cycle
        blk = rnd_block();
        put_block(blk);
        bus(1'b1, 8'h08, 32'h2);                 // accepted at edge E0
        repeat (63) @(posedge clk);
        bus(1'b0, 8'h09, 0);                     // sampled before E64
        chk("R5 status busy", rd, 32'h0);
        bus(1'b1, 8'h30, 32'hdeadbeef);          // FOLD cycle, sampled at E65
        e_save = er;
        bus(1'b0, 8'h09, 0);                     // before E66
        chk("R5 status done", rd, 32'h3);
        chk("R6 fold write no err", e_save, 1'b0);
        get_digest(dg);
        exp_h = model(exp_h, blk);
        chk("R6 fold write ignored", dg, exp_h);

        // R6 command during busy
        blk = rnd_block();
        put_block(blk);
        bus(1'b1, 8'h08, 32'h2);
        bus(1'b1, 8'h08, 32'h1);
        bus(1'b1, 8'h31, 32'h12345678);
        wait_done();
        get_digest(dg);
        exp_h = model(exp_h, blk);
        chk("R6 busy command ignored", dg, exp_h);

        // R7 error decode
        bus(1'b0, 8'h05, 0); chk("R7 unmapped read err", er, 1'b1);
        bus(1'b0, 8'h28, 0); chk("R7 gap read err", er, 1'b1);
        bus(1'b1, 8'h38, 0); chk("R7 unmapped write err", er, 1'b1);
        bus(1'b1, 8'h20, 32'h0); chk("R7 digest write err", er, 1'b1);
        bus(1'b0, 8'h20, 0); chk("R7 digest unchanged", rd, exp_h[255:224]);
        bus(1'b1, 8'h09, 32'h0); chk("R7 status write err", er, 1'b1);
        bus(1'b0, 8'h09, 0); chk("R7 status unchanged", rd, 32'h3);
        bus(1'b0, 8'h13, 0); chk("R7 block read ok", {er, rd}, {1'b0, blk[415:384]});
        bus(1'b1, 8'h37, 32'hcafef00d); chk("R7 chain write ok", er, 1'b0);
        bus(1'b0, 8'h27, 0); chk("R4 chain word 7", rd, 32'hcafef00d);

        // R8 both command bits: init wins
        s = rnd_state();
        put_state(s);
        blk = rnd_block();
        hash(2'b11, blk, dg);
        exp_h = model(IV, blk);
        chk("R8 init priority", dg, exp_h);

        // R9 self-clearing command
        bus(1'b0, 8'h08, 0); chk("R9 command reads 0", rd, 32'h0);
        repeat (100) @(posedge clk);
        bus(1'b0, 8'h09, 0); chk("R9 stays idle", rd, 32'h3);
        get_digest(dg); chk("R9 digest held", dg, exp_h);

        // Random chained traffic
        for (int it = 0; it < 12; it++) begin
            int mode;
            mode = $urandom_range(0, 2);
            blk  = rnd_block();
            if (mode == 0) begin
                hash(2'b01, blk, dg);
                exp_h = model(IV, blk);
                chk("R2 random init", dg, exp_h);
            end else if (mode == 1) begin
                hash(2'b10, blk, dg);
                exp_h = model(exp_h, blk);
                chk("R3 random next", dg, exp_h);
            end else begin
                s = rnd_state();
                put_state(s);
                hash(2'b10, blk, dg);
                exp_h = model(s, blk);
                chk("R4 random restore", dg, exp_h);
            end
        end

        finish_run();
    end
endmodule